// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels that share one 8-bit mode register and one 8-bit control register. Each channel advances on either an internal machine-cycle tick or a falling edge of its own external count pin. A gate option can make the run condition also depend on an active-low interrupt pin. When a channel rolls over, it sets an overflow flag, and that flag serves as an interrupt request. The counters are loaded one byte at a time through a small write port. Their values, the control register and the two flags are driven out continuously.

There are four counting modes: a 13-bit prescaled counter, a 16-bit counter, an 8-bit counter that reloads its low byte from its high byte, and a split mode. In split mode, channel 0 becomes two independent 8-bit counters. Its high byte borrows channel 1's run bit and channel 1's overflow flag. Channel 1 placed in split mode holds its count. Channel 1 also drives a one-cycle overflow strobe that a serial baud generator can use.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all four counter bytes, the mode register and the control register are zero.
- R2: The mode register gives channel 0 bits [3:0] and channel 1 bits [7:4]. Inside each nibble the fields are gate (bit 3), count-source select (bit 2) and mode (bits 1:0). Mode encodings: 0 = 13-bit, 1 = 16-bit, 2 = 8-bit auto-reload, 3 = split/hold.
- R3: In the control register, bit 4 is the channel 0 run bit, bit 5 the channel 0 flag, bit 6 the channel 1 run bit and bit 7 the channel 1 flag. Bits 3:0 are stored and read back exactly as written, and they have no effect on counting.
- R4: With gate = 0, a channel counts while its run bit is set. With gate = 1, it counts only while its run bit is set and its synchronised interrupt pin is high.
- R5: With source select = 1, a channel counts one event per falling edge of its synchronised count pin, and ticks are ignored. With source select = 0, it counts ticks.
- R6: Mode 0 counts a 13-bit value made of the high byte (upper 8 bits) and low byte bits [4:0]. Low byte bits [7:5] stay unchanged. Going from 0x1FFF to zero sets the flag.
- R7: Mode 1 counts a 16-bit value, high byte above low byte. Going from 0xFFFF to zero sets the flag.
- R8: In mode 2, when the low byte overflows it is loaded from the high byte in that same event and the flag is set. The high byte never changes.
- R9: In channel 0 split mode, the low byte counts under channel 0's own controls and sets the channel 0 flag. The high byte counts ticks while the channel 1 run bit is set, and it sets the channel 1 flag on rollover.
- R10: Channel 1 in mode 3 holds both of its bytes.
- R11: The strobe pulses for one cycle, one cycle after each channel 1 rollover. While channel 0 is in split mode, a channel 1 rollover does not set the channel 1 flag.
- R12: A counter byte write wins over a count in the same cycle, and that cycle's overflow is dropped. A flag set by hardware in the same cycle as a control-register write ends up set.
- R13: Writing 0 to a flag bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle tick, one clock wide |
| t0_pin | input | 1 | Channel 0 external count pin |
| t1_pin | input | 1 | Channel 1 external count pin |
| int0_n | input | 1 | Channel 0 gate pin |
| int1_n | input | 1 | Channel 1 gate pin |
| tmod_we | input | 1 | Mode register write enable |
| tmod_wdata | input | 8 | Mode register write data |
| tcon_we | input | 1 | Control register write enable |
| tcon_wdata | input | 8 | Control register write data |
| cnt_we | input | 1 | Counter byte write enable |
| cnt_sel | input | 2 | Byte select: bit 1 channel, bit 0 high byte |
| cnt_wdata | input | 8 | Counter byte write data |
| tl0 | output | 8 | Channel 0 low byte |
| th0 | output | 8 | Channel 0 high byte |
| tl1 | output | 8 | Channel 1 low byte |
| th1 | output | 8 | Channel 1 high byte |
| tcon_q | output | 8 | Control register contents |
| tf0 | output | 1 | Channel 0 overflow request |
| tf1 | output | 1 | Channel 1 overflow request |
| t1_ovf_stb | output | 1 | Channel 1 rollover strobe |

## Verification
A wrong count, a wrong reload or a stray held value shows up on the counter bytes at the tick right after the fault. A misrouted overflow shows up only at a rollover: the wrong flag bit rises, or the strobe count is off, within one cycle of the wrap. For that reason the sweeps run every mode through several full wraps, starting from near-overflow values, so each overflow path is exercised. A synchroniser or edge-detect fault appears a few cycles after a pin edge, as a missing or doubled count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CFG_W = 8;

   typedef enum logic [1:0] {
      MODE_13  = 2'd0,
      MODE_16  = 2'd1,
      MODE_8R  = 2'd2,
      MODE_SPL = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      ext_src;
      tmr_mode_e mode;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o
);
   logic [STAGES-1:0] sr;

   initial assert (STAGES >= 2) else $error("tmr_pin_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], pin_i};
   end

   assign lvl_o = sr[STAGES-1];
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic fall_o
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl_i;
   end

   assign fall_o = prev & ~lvl_i;

   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LOW_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              ev_lo,
   input  logic              ev_hi,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] tl,
   output logic [BYTE_W-1:0] th,
   output logic              ovf_main,
   output logic              ovf_hi
);
   localparam int PAD_W = BYTE_W - LOW_W;

   logic [BYTE_W-1:0] tl_n, th_n;
   logic              raw_main, raw_hi;
   logic              lo_full, hi_full, low5_full;

   initial assert (LOW_W >= 1 && LOW_W < BYTE_W) else $error("tmr_core: LOW_W out of range");

   assign lo_full   = &tl;
   assign hi_full   = &th;
   assign low5_full = &tl[LOW_W-1:0];

   always_comb begin
      tl_n     = tl;
      th_n     = th;
      raw_main = 1'b0;
      raw_hi   = 1'b0;
      unique case (mode)
         MODE_13: if (ev_lo) begin
            if (low5_full) begin
               tl_n     = {tl[BYTE_W-1:LOW_W], {LOW_W{1'b0}}};
               th_n     = th + 1'b1;
               raw_main = hi_full;
            end else begin
               tl_n = {tl[BYTE_W-1:LOW_W], tl[LOW_W-1:0] + 1'b1};
            end
         end
         MODE_16: if (ev_lo) begin
            {th_n, tl_n} = {th, tl} + 1'b1;
            raw_main     = lo_full & hi_full;
         end
         MODE_8R: if (ev_lo) begin
            tl_n     = lo_full ? th : tl + 1'b1;
            raw_main = lo_full;
         end
         MODE_SPL: begin
            if (ev_lo) begin
               tl_n     = tl + 1'b1;
               raw_main = lo_full;
            end
            if (ev_hi) begin
               th_n   = th + 1'b1;
               raw_hi = hi_full;
            end
         end
         default: ;
      endcase
   end

   assign ovf_main = raw_main & ~wr_lo & ~wr_hi;
   assign ovf_hi   = raw_hi & ~wr_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tl <= '0;
         th <= '0;
      end else begin
         tl <= wr_lo ? wdata : tl_n;
         th <= wr_hi ? wdata : th_n;
      end
   end

   a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_13 && !wr_lo) |=> tl[BYTE_W-1:LOW_W] == $past(tl[BYTE_W-1:LOW_W]));
   a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_16 && ovf_main) |=> (tl == '0 && th == '0));
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_8R && ovf_main) |=> tl == $past(th));
   a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> tl == $past(wdata));

   logic [PAD_W-1:0] unused_pad;
   assign unused_pad = '0;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter int M13_LOW_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              t0_pin,
   input  logic              t1_pin,
   input  logic              int0_n,
   input  logic              int1_n,
   input  logic              tmod_we,
   input  logic [CFG_W-1:0]  tmod_wdata,
   input  logic              tcon_we,
   input  logic [CFG_W-1:0]  tcon_wdata,
   input  logic              cnt_we,
   input  logic [1:0]        cnt_sel,
   input  logic [BYTE_W-1:0] cnt_wdata,
   output logic [BYTE_W-1:0] tl0,
   output logic [BYTE_W-1:0] th0,
   output logic [BYTE_W-1:0] tl1,
   output logic [BYTE_W-1:0] th1,
   output logic [CFG_W-1:0]  tcon_q,
   output logic              tf0,
   output logic              tf1,
   output logic              t1_ovf_stb
);
   localparam int NCH     = 2;
   localparam int NIB_W   = CFG_W / NCH;
   localparam int RUN0_B  = 4;
   localparam int FLAG0_B = 5;
   localparam int RUN1_B  = 6;
   localparam int FLAG1_B = 7;

   initial assert (CFG_W == 8 && NIB_W == 4) else $error("tmr_pair: register width must be 8");

   logic [CFG_W-1:0]  tmod_q;
   logic [NCH-1:0]    cnt_pin, gate_pin, cnt_lvl, gate_lvl, cnt_fall;
   logic [NCH-1:0]    run_bit, ev_lo, ev_hi, wr_lo, wr_hi, ovf_main, ovf_hi;
   logic [BYTE_W-1:0] tl_a [NCH];
   logic [BYTE_W-1:0] th_a [NCH];
   tmr_cfg_t          cfg  [NCH];
   logic              t0_split, set_f0, set_f1;

   assign cnt_pin  = {t1_pin, t0_pin};
   assign gate_pin = {int1_n, int0_n};
   assign run_bit  = {tcon_q[RUN1_B], tcon_q[RUN0_B]};
   assign t0_split = (cfg[0].mode == MODE_SPL);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign cfg[c] = tmr_cfg_t'(tmod_q[c*NIB_W +: NIB_W]);

      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
         .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin[c]), .lvl_o(cnt_lvl[c]));
      tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
         .clk(clk), .rst_n(rst_n), .pin_i(gate_pin[c]), .lvl_o(gate_lvl[c]));
      tmr_fall_det u_fall (
         .clk(clk), .rst_n(rst_n), .lvl_i(cnt_lvl[c]), .fall_o(cnt_fall[c]));

      logic src_ev, run_ok;
      assign src_ev = cfg[c].ext_src ? cnt_fall[c] : tick;
      assign run_ok = run_bit[c] & (~cfg[c].gate | gate_lvl[c]);

      if (c == 0) begin : g_split_owner
         assign ev_lo[c] = run_ok & src_ev;
         assign ev_hi[c] = tick & run_bit[1];
      end else begin : g_holder
         assign ev_lo[c] = run_ok & src_ev & (cfg[c].mode != MODE_SPL);
         assign ev_hi[c] = 1'b0;
      end

      assign wr_lo[c] = cnt_we & (cnt_sel[1] == c[0]) & ~cnt_sel[0];
      assign wr_hi[c] = cnt_we & (cnt_sel[1] == c[0]) &  cnt_sel[0];

      tmr_core #(.BYTE_W(BYTE_W), .LOW_W(M13_LOW_W)) u_core (
         .clk(clk), .rst_n(rst_n), .mode(cfg[c].mode),
         .ev_lo(ev_lo[c]), .ev_hi(ev_hi[c]),
         .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]), .wdata(cnt_wdata),
         .tl(tl_a[c]), .th(th_a[c]),
         .ovf_main(ovf_main[c]), .ovf_hi(ovf_hi[c]));
   end

   assign set_f0 = ovf_main[0];
   assign set_f1 = t0_split ? ovf_hi[0] : ovf_main[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmod_q     <= '0;
         tcon_q     <= '0;
         t1_ovf_stb <= 1'b0;
      end else begin
         if (tmod_we) tmod_q <= tmod_wdata;
         tcon_q <= tcon_we ? tcon_wdata : tcon_q;
         if (set_f0) tcon_q[FLAG0_B] <= 1'b1;
         if (set_f1) tcon_q[FLAG1_B] <= 1'b1;
         t1_ovf_stb <= ovf_main[1] | ovf_hi[1];
      end
   end

   assign tl0 = tl_a[0];
   assign th0 = th_a[0];
   assign tl1 = tl_a[1];
   assign th1 = th_a[1];
   assign tf0 = tcon_q[FLAG0_B];
   assign tf1 = tcon_q[FLAG1_B];

   a_r3_flag0_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tf0) |-> $past(ovf_main[0] | (tcon_we & tcon_wdata[FLAG0_B])));
   a_r10_t1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[1].mode == MODE_SPL && !(cnt_we && cnt_sel[1])) |=> $stable({tl1, th1}));
   a_r9_hi_needs_run1: assert property (@(posedge clk) disable iff (!rst_n)
      (t0_split && !tcon_q[RUN1_B] && !wr_hi[0]) |=> $stable(th0));
endmodule

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic t0_pin = 1'b1, t1_pin = 1'b1, int0_n = 1'b1, int1_n = 1'b1;
   logic tmod_we = 1'b0, tcon_we = 1'b0, cnt_we = 1'b0;
   logic [7:0] tmod_wdata = '0, tcon_wdata = '0, cnt_wdata = '0;
   logic [1:0] cnt_sel = '0;
   logic [7:0] tl0, th0, tl1, th1, tcon_q;
   logic tf0, tf1, t1_ovf_stb;

   int errors = 0, checks = 0, stb_cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_pair dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .t0_pin(t0_pin), .t1_pin(t1_pin),
      .int0_n(int0_n), .int1_n(int1_n), .tmod_we(tmod_we), .tmod_wdata(tmod_wdata),
      .tcon_we(tcon_we), .tcon_wdata(tcon_wdata), .cnt_we(cnt_we), .cnt_sel(cnt_sel),
      .cnt_wdata(cnt_wdata), .tl0(tl0), .th0(th0), .tl1(tl1), .th1(th1),
      .tcon_q(tcon_q), .tf0(tf0), .tf1(tf1), .t1_ovf_stb(t1_ovf_stb));

   always @(negedge clk) if (rst_n && t1_ovf_stb) stb_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_tmod(input logic [7:0] v);
      tmod_we = 1'b1; tmod_wdata = v; @(negedge clk); tmod_we = 1'b0;
   endtask
   task automatic wr_tcon(input logic [7:0] v);
      tcon_we = 1'b1; tcon_wdata = v; @(negedge clk); tcon_we = 1'b0;
   endtask
   task automatic wr_cnt(input logic [1:0] s, input logic [7:0] v);
      cnt_we = 1'b1; cnt_sel = s; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
   endtask
   task automatic run_ticks(input int n);
      tick = 1'b1; repeat (n) @(negedge clk); tick = 1'b0;
      @(negedge clk);
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   int s_th [3] = '{8'hFF, 8'hF0, 8'h00};
   int s_tl [3] = '{8'hFA, 8'h3C, 8'hFF};
   int s_n  [3] = '{1, 7, 260};

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 counters", {tl0, th0, tl1, th1}, 0);
      chk("R1 tcon", tcon_q, 0);
      chk("R1 flags", {tf0, tf1}, 0);

      // R2/R6/R7/R8/R11 sweep over both channels and three counting modes
      for (int ch = 0; ch < 2; ch++) begin
         for (int m = 0; m < 3; m++) begin
            for (int si = 0; si < 3; si++) begin
               for (int ni = 0; ni < 3; ni++) begin
                  int th_s, tl_s, n, e_tl, e_th, e_ovf, v, s, p, rem;
                  th_s = s_th[si]; tl_s = s_tl[si]; n = s_n[ni];
                  e_th = th_s; e_ovf = 0;
                  if (m == 1) begin
                     v = th_s * 256 + tl_s; s = v + n; e_ovf = s / 65536;
                     e_tl = s % 256; e_th = (s % 65536) / 256;
                  end else if (m == 0) begin
                     v = th_s * 32 + (tl_s & 31); s = v + n; e_ovf = s / 8192;
                     e_tl = (tl_s & 8'hE0) | (s % 32); e_th = (s % 8192) / 32;
                  end else begin
                     if (tl_s + n <= 255) e_tl = tl_s + n;
                     else begin
                        rem = n - (256 - tl_s); p = 256 - th_s;
                        e_tl = th_s + (rem % p); e_ovf = 1 + rem / p;
                     end
                  end
                  wr_tcon(8'h00);
                  wr_tmod(8'(m << (4 * ch)));
                  wr_cnt(2'(ch * 2), 8'(tl_s));
                  wr_cnt(2'(ch * 2 + 1), 8'(th_s));
                  wr_tcon(ch == 0 ? 8'h10 : 8'h40);
                  stb_cnt = 0;
                  run_ticks(n);
                  if (ch == 0) begin
                     chk($sformatf("R6/R7/R8 tl0 m%0d", m), tl0, e_tl);
                     chk($sformatf("R6/R7/R8 th0 m%0d", m), th0, e_th);
                     chk($sformatf("R3 tf0 m%0d", m), tf0, e_ovf != 0);
                  end else begin
                     chk($sformatf("R2 tl1 m%0d", m), tl1, e_tl);
                     chk($sformatf("R2 th1 m%0d", m), th1, e_th);
                     chk($sformatf("R3 tf1 m%0d", m), tf1, e_ovf != 0);
                     chk($sformatf("R11 strobes m%0d", m), stb_cnt, e_ovf);
                  end
               end
            end
         end
      end

      // R4 gating
      wr_tcon(8'h00); wr_tmod(8'h09); wr_cnt(2'd0, 8'h00); wr_cnt(2'd1, 8'h00);
      wr_tcon(8'h10); int0_n = 1'b0; idle(4);
      run_ticks(10);
      chk("R4 gate low blocks", tl0, 0);
      int0_n = 1'b1; idle(4);
      run_ticks(10);
      chk("R4 gate high counts", tl0, 10);
      wr_tmod(8'h01); int0_n = 1'b0; idle(4);
      run_ticks(5);
      chk("R4 gate off ignores pin", tl0, 15);
      wr_tcon(8'h00);
      run_ticks(5);
      chk("R4 run bit clear stops", tl0, 15);
      int0_n = 1'b1;

      // R5 external edge counting
      wr_tmod(8'h05); wr_cnt(2'd0, 8'h00); wr_cnt(2'd1, 8'h00); wr_tcon(8'h10);
      run_ticks(10);
      chk("R5 ticks ignored", tl0, 0);
      for (int k = 0; k < 7; k++) begin
         t0_pin = 1'b0; idle(4); t0_pin = 1'b1; idle(4);
      end
      chk("R5 seven falling edges", tl0, 7);
      chk("R5 high byte", th0, 0);

      // R9 split mode
      wr_tcon(8'h00); wr_tmod(8'h03);
      wr_cnt(2'd1, 8'hFE); wr_cnt(2'd0, 8'h10);
      wr_tcon(8'h40);
      run_ticks(2);
      chk("R9 hi byte wraps", th0, 0);
      chk("R9 hi sets tf1", tf1, 1);
      chk("R9 lo held without run0", tl0, 8'h10);
      chk("R9 tf0 untouched", tf0, 0);
      wr_tcon(8'h10);
      run_ticks(8'hF0);
      chk("R9 lo wraps", tl0, 0);
      chk("R9 lo sets tf0", tf0, 1);
      chk("R9 hi held without run1", th0, 0);

      // R10 hold in channel 1
      wr_tcon(8'h00); wr_tmod(8'h31);
      wr_cnt(2'd2, 8'h34); wr_cnt(2'd3, 8'h12);
      wr_tcon(8'h40); stb_cnt = 0;
      run_ticks(20);
      chk("R10 tl1 held", tl1, 8'h34);
      chk("R10 th1 held", th1, 8'h12);
      chk("R10 no strobe", stb_cnt, 0);

      // R11 channel 1 rollover in split mode: strobe but no flag
      wr_tcon(8'h00); wr_tmod(8'h13);
      wr_cnt(2'd2, 8'hFE); wr_cnt(2'd3, 8'hFF); wr_cnt(2'd1, 8'h00);
      wr_tcon(8'h40); stb_cnt = 0;
      run_ticks(3);
      chk("R11 strobe once", stb_cnt, 1);
      chk("R11 tf1 not set", tf1, 0);
      chk("R11 tl1", tl1, 1);
      chk("R11 th0 counts under run1", th0, 3);

      // R12 write beats count, flag beats control write
      wr_tcon(8'h00); wr_tmod(8'h11); wr_cnt(2'd0, 8'h20); wr_tcon(8'h10);
      tick = 1'b1; cnt_we = 1'b1; cnt_sel = 2'd0; cnt_wdata = 8'h55;
      @(negedge clk); tick = 1'b0; cnt_we = 1'b0;
      chk("R12 write wins", tl0, 8'h55);
      wr_cnt(2'd0, 8'hFF); wr_cnt(2'd1, 8'hFF);
      tick = 1'b1; tcon_we = 1'b1; tcon_wdata = 8'h10;
      @(negedge clk); tick = 1'b0; tcon_we = 1'b0;
      chk("R12 flag survives write", tf0, 1);
      chk("R12 wrap value", {th0, tl0}, 0);

      // R13 clear by software
      wr_tcon(8'h10);
      chk("R13 tf0 cleared", tf0, 0);

      // R3 low control bits are storage only
      wr_tcon(8'h0F);
      chk("R3 readback", tcon_q, 8'h0F);
      run_ticks(5);
      chk("R3 no counting", {tl0, th0}, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule